// File: doc/BRIEF.md
# Timer Event Capture Unit

This block records when things happen on one external input pin. Each qualifying pin transition latches the count of one of two free-running timers into a four-entry capture queue. Software later drains the queue through a read port. A 3-bit mode code picks which transitions qualify: every edge, falling edges only, rising edges only, or every 4th or 16th rising edge through a prescaler. Two further codes make the unit inert. A final code turns the pin into a plain interrupt source that stores nothing.

An interrupt pulse can be spread over several captures by a 2-bit ratio field, except in every-edge mode, which signals every transition. The queue reports not-empty and a sticky overflow. A stop-in-idle control freezes the unit while the chip-level idle indication is high. The pin passes through a two-flop synchronizer before edge detection, so a capture carries the timer count seen two clocks after the pin moved.

Top module: `edgeCapture`

## Requirements
- R1: After reset, and whenever the mode code is 000, the queue is empty, overflow is 0, the prescaler and capture-ratio counters are cleared, and no interrupt pulse is issued. Code 110 stores nothing and raises no interrupt.
- R2: A pin change driven just after rising clock edge c is stored with the timer count present during the cycle that follows edge c+2.
- R3: Code 001 stores on rising and falling edges, code 010 on falling edges only, and code 011 on rising edges only.
- R4: Code 100 stores on every 4th rising edge and code 101 on every 16th rising edge, counted from the last clear.
- R5: With timer select 1 the stored value is timer A; with timer select 0 it is timer B.
- R6: The queue holds 4 entries of 16 bits and returns them oldest first. The read data shows the oldest entry while not-empty is 1. A read strobe pops one entry, and a read strobe on an empty queue changes nothing.
- R7: A capture that arrives while 4 entries are held, with no read in the same cycle, is dropped and sets overflow. Overflow stays 1 until the mode code is 000.
- R8: In codes 010 to 101, the ratio field n (00 to 11) issues one interrupt per n+1 stored captures.
- R9: In code 001 every rising and every falling edge issues an interrupt, whatever the ratio field holds.
- R10: Code 111 stores nothing and issues an interrupt on each rising pin edge, and none on falling edges.
- R11: While stop-in-idle and idle are both 1, pin edges store nothing and issue no interrupt. With stop-in-idle at 0, the unit works normally during idle.
- R12: Any change of the mode code restarts the prescaler count.
- R13: Each interrupt is a pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | Raw asynchronous event pin |
| timerA | input | 16 | Count of timer A (selected by timerSel=1) |
| timerB | input | 16 | Count of timer B (selected by timerSel=0) |
| modeSel | input | 3 | Edge / prescale / interrupt mode code |
| timerSel | input | 1 | Timer source select |
| perIrq | input | 2 | Captures per interrupt minus one |
| stopInIdle | input | 1 | Freeze the unit while idle is asserted |
| idleIn | input | 1 | Chip idle indication |
| rdPop | input | 1 | Pop the oldest queue entry |
| rdData | output | 16 | Oldest queued capture |
| notEmpty | output | 1 | Queue holds at least one entry |
| overflow | output | 1 | Sticky dropped-capture flag |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions take for granted that the control fields are static register outputs that change only on clock edges. They also assume a read strobe is a level sampled at the clock and not a pulse between edges. The bench changes modeSel, timerSel and perIrq only at the falling clock edge, and only after the pin has been idle for several cycles. It holds the pin steady for at least four clocks between changes, so each edge is seen once and consecutive interrupts cannot merge into one wide pulse. Read strobes last one full cycle and are never issued in the same cycle as a pin transition.

// File: rtl/edgeCapturePkg.sv
package edgeCapturePkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'b000,
    MODE_ANY    = 3'b001,
    MODE_FALL   = 3'b010,
    MODE_RISE   = 3'b011,
    MODE_DIV4   = 3'b100,
    MODE_DIV16  = 3'b101,
    MODE_RSVD   = 3'b110,
    MODE_EXTIRQ = 3'b111
  } capMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;   // store the selected timer count
    logic flush;  // empty the queue and clear overflow
  } capStrobe_t;

endpackage

// File: rtl/edgeCaptureCtrl.sv
module edgeCaptureCtrl
  import edgeCapturePkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int PRE_LO   = 4,
  parameter int PRE_HI   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pinIn,
  input  logic [2:0] modeSel,
  input  logic [1:0] perIrq,
  input  logic       stopInIdle,
  input  logic       idleIn,
  output capStrobe_t strb,
  output logic       irqPulse
);

  localparam int PW = $clog2(PRE_HI);

  // input synchronizer chain
  logic [SYNC_LEN-1:0] syncQ;
  for (genvar g = 0; g < SYNC_LEN; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ[g] <= 1'b0;
        else        syncQ[g] <= pinIn;
      end
    end else begin : gRest
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ[g] <= 1'b0;
        else        syncQ[g] <= syncQ[g-1];
      end
    end
  end

  logic pinS, prevQ;
  assign pinS = syncQ[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prevQ <= 1'b0;
    else        prevQ <= pinS;
  end

  logic riseEdge, fallEdge;
  assign riseEdge = pinS & ~prevQ;
  assign fallEdge = ~pinS & prevQ;

  capMode_t mode, modeQ;
  assign mode = capMode_t'(modeSel);

  always_ff @(posedge clk) begin
    if (!rst_n) modeQ <= MODE_OFF;
    else        modeQ <= mode;
  end

  logic run, modeChg, isPre, isCounted;
  assign run       = !(stopInIdle && idleIn);
  assign modeChg   = (mode != modeQ);
  assign isPre     = (mode == MODE_DIV4) || (mode == MODE_DIV16);
  assign isCounted = (mode == MODE_FALL) || (mode == MODE_RISE) || isPre;

  // prescaler
  logic [PW-1:0] preCnt, preLast;
  logic          preHit;
  assign preLast = (mode == MODE_DIV16) ? PW'(PRE_HI - 1) : PW'(PRE_LO - 1);
  assign preHit  = (preCnt == preLast);

  always_ff @(posedge clk) begin
    if (!rst_n || mode == MODE_OFF || modeChg) preCnt <= '0;
    else if (run && isPre && riseEdge)         preCnt <= preHit ? '0 : preCnt + PW'(1);
  end

  logic capEvt;
  always_comb begin
    case (mode)
      MODE_ANY:              capEvt = riseEdge | fallEdge;
      MODE_FALL:             capEvt = fallEdge;
      MODE_RISE:             capEvt = riseEdge;
      MODE_DIV4, MODE_DIV16: capEvt = riseEdge & preHit & ~modeChg;
      default:               capEvt = 1'b0;
    endcase
    capEvt = capEvt & run;
  end

  // captures-per-interrupt counter
  logic [1:0] irqCnt;
  logic       irqHit;
  assign irqHit = (irqCnt == perIrq);

  always_ff @(posedge clk) begin
    if (!rst_n || mode == MODE_OFF) irqCnt <= '0;
    else if (capEvt && isCounted)   irqCnt <= irqHit ? 2'd0 : irqCnt + 2'd1;
  end

  logic irqNext;
  always_comb begin
    case (mode)
      MODE_ANY:    irqNext = riseEdge | fallEdge;
      MODE_EXTIRQ: irqNext = riseEdge;
      default:     irqNext = capEvt & isCounted & irqHit;
    endcase
    irqNext = irqNext & run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irqPulse <= 1'b0;
    else        irqPulse <= irqNext;
  end

  assign strb.push  = capEvt;
  assign strb.flush = (mode == MODE_OFF);

endmodule

// File: rtl/edgeCaptureData.sv
module edgeCaptureData
  import edgeCapturePkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  capStrobe_t       strb,
  input  logic [WIDTH-1:0] timerA,
  input  logic [WIDTH-1:0] timerB,
  input  logic             timerSel,
  input  logic             rdPop,
  output logic [WIDTH-1:0] rdData,
  output logic             notEmpty,
  output logic             overflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;

  logic [WIDTH-1:0] sample;
  assign sample = timerSel ? timerA : timerB;

  logic isFull, doPop, doPush, dropped;
  assign isFull  = (count == CW'(DEPTH));
  assign doPop   = rdPop && (count != '0);
  assign doPush  = strb.push && (!isFull || doPop);
  assign dropped = strb.push && isFull && !doPop;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || strb.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CW'(1);
      else if (doPop && !doPush) count <= count - CW'(1);
      if (dropped) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (doPush && !strb.flush) begin
      mem[wrPtr] <= sample;
    end
  end

  assign rdData   = mem[rdPtr];
  assign notEmpty = (count != '0);

endmodule

// File: rtl/edgeCapture.sv
module edgeCapture
  import edgeCapturePkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int DEPTH    = 4,
  parameter int SYNC_LEN = 2,
  parameter int PRE_LO   = 4,
  parameter int PRE_HI   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pinIn,
  input  logic [WIDTH-1:0] timerA,
  input  logic [WIDTH-1:0] timerB,
  input  logic [2:0]       modeSel,
  input  logic             timerSel,
  input  logic [1:0]       perIrq,
  input  logic             stopInIdle,
  input  logic             idleIn,
  input  logic             rdPop,
  output logic [WIDTH-1:0] rdData,
  output logic             notEmpty,
  output logic             overflow,
  output logic             irqPulse
);

  capStrobe_t strb;

  edgeCaptureCtrl #(
    .SYNC_LEN(SYNC_LEN), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .modeSel(modeSel),
    .perIrq(perIrq), .stopInIdle(stopInIdle), .idleIn(idleIn),
    .strb(strb), .irqPulse(irqPulse)
  );

  edgeCaptureData #(
    .WIDTH(WIDTH), .DEPTH(DEPTH)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb), .timerA(timerA),
    .timerB(timerB), .timerSel(timerSel), .rdPop(rdPop),
    .rdData(rdData), .notEmpty(notEmpty), .overflow(overflow)
  );

endmodule

// File: rtl/edgeCaptureChk.sv
module edgeCaptureChk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] modeSel,
  input logic       stopInIdle,
  input logic       idleIn,
  input logic       rdPop,
  input logic       notEmpty,
  input logic       overflow,
  input logic       irqPulse,
  input logic       pushStb
);

  a_r1_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    modeSel == 3'b000 |=> !notEmpty && !overflow);

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    modeSel == 3'b000 |=> !irqPulse);

  a_r10_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 3'b111 || modeSel == 3'b110 || modeSel == 3'b000) |-> !pushStb);

  a_r6_drain_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(notEmpty) |-> $past(rdPop) || ($past(modeSel) == 3'b000));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && modeSel != 3'b000 |=> overflow);

  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(pushStb) && $past(notEmpty));

  a_r11_halt_nopush: assert property (@(posedge clk) disable iff (!rst_n)
    stopInIdle && idleIn |-> !pushStb);

  a_r11_halt_noirq: assert property (@(posedge clk) disable iff (!rst_n)
    stopInIdle && idleIn |=> !irqPulse);

endmodule

bind edgeCapture edgeCaptureChk u_chk (
  .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .stopInIdle(stopInIdle),
  .idleIn(idleIn), .rdPop(rdPop), .notEmpty(notEmpty), .overflow(overflow),
  .irqPulse(irqPulse), .pushStb(strb.push)
);

// File: tb/edgeCapture_tb.sv
`timescale 1ns/1ps
module edgeCapture_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pinIn = 1'b0;
  logic [15:0] timerA, timerB;
  logic [2:0]  modeSel = 3'b000;
  logic        timerSel = 1'b0;
  logic [1:0]  perIrq = 2'b00;
  logic        stopInIdle = 1'b0;
  logic        idleIn = 1'b0;
  logic        rdPop = 1'b0;
  logic [15:0] rdData;
  logic        notEmpty, overflow, irqPulse;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int irqCount = 0;
  logic prevIrq = 1'b0;
  logic [15:0] expQ[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] fA(input int c);
    return 16'(c * 3);
  endfunction
  function automatic logic [15:0] fB(input int c);
    return 16'(c) ^ 16'hA5A5;
  endfunction

  assign timerA = fA(cyc);
  assign timerB = fB(cyc);

  edgeCapture u_dut (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .timerA(timerA), .timerB(timerB),
    .modeSel(modeSel), .timerSel(timerSel), .perIrq(perIrq),
    .stopInIdle(stopInIdle), .idleIn(idleIn), .rdPop(rdPop),
    .rdData(rdData), .notEmpty(notEmpty), .overflow(overflow), .irqPulse(irqPulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // interrupt monitor (R13 pulse width)
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (irqPulse) irqCount++;
      if (irqPulse && prevIrq) chk(1'b0, "R13 pulse wider than one clock", 2, 1);
      prevIrq = irqPulse;
    end
  end

  // scoreboard monitor: compares each popped entry
  always @(negedge clk) begin
    #2;
    if (rdPop) begin
      if (expQ.size() == 0) begin
        chk(notEmpty == 1'b0, "R6 read on empty queue", notEmpty, 0);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk(notEmpty == 1'b1, "R6 not-empty while data pending", notEmpty, 1);
        chk(rdData == e, "R2 R5 R6 captured value", rdData, e);
      end
    end
  end

  // driver: move the pin, optionally expect a capture
  task automatic drive(input bit v, input bit expCap);
    @(negedge clk);
    pinIn = v;
    if (expCap) expQ.push_back(timerSel ? fA(cyc + 2) : fB(cyc + 2));
    repeat (4) @(negedge clk);
    #5;
  endtask

  task automatic risePulse(input bit capRise, input bit capFall);
    drive(1'b1, capRise);
    drive(1'b0, capFall);
  endtask

  task automatic popOne();
    @(negedge clk);
    rdPop = 1'b1;
    @(negedge clk);
    rdPop = 1'b0;
    #5;
  endtask

  task automatic drain();
    while (expQ.size() > 0) popOne();
    chk(notEmpty == 1'b0, "R6 empty after draining", notEmpty, 0);
  endtask

  task automatic setMode(input logic [2:0] m);
    @(negedge clk);
    modeSel = m;
    @(negedge clk);
    #5;
  endtask

  task automatic clearAll();
    setMode(3'b000);
  endtask

  initial begin : watchdog
    #(20ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #5;
    // R1 reset state
    chk(notEmpty == 1'b0, "R1 reset not-empty", notEmpty, 0);
    chk(overflow == 1'b0, "R1 reset overflow", overflow, 0);
    chk(irqCount == 0, "R1 reset irq", irqCount, 0);

    // R1 off mode: edges ignored
    base = irqCount;
    risePulse(1'b0, 1'b0);
    chk(notEmpty == 1'b0 && irqCount == base, "R1 mode 000 inert", irqCount - base, 0);

    // R3 rising only, R5 timer A, R8 ratio 1, R13
    timerSel = 1'b1;
    setMode(3'b011);
    base = irqCount;
    drive(1'b1, 1'b1);
    chk(irqCount - base == 1, "R13 R8 one irq per rising capture", irqCount - base, 1);
    drive(1'b0, 1'b0);
    chk(irqCount - base == 1, "R3 falling edge ignored in 011", irqCount - base, 1);
    drain();

    // R3 falling only, R5 timer B
    clearAll();
    timerSel = 1'b0;
    setMode(3'b010);
    risePulse(1'b0, 1'b1);
    drain();

    // R9 every edge, ratio field ignored
    clearAll();
    perIrq = 2'b11;
    setMode(3'b001);
    base = irqCount;
    risePulse(1'b1, 1'b1);
    chk(irqCount - base == 2, "R9 irq on both edges", irqCount - base, 2);
    drain();

    // R8 one irq per three captures
    clearAll();
    perIrq = 2'b10;
    timerSel = 1'b1;
    setMode(3'b011);
    base = irqCount;
    risePulse(1'b1, 1'b0);
    risePulse(1'b1, 1'b0);
    chk(irqCount - base == 0, "R8 no irq before third capture", irqCount - base, 0);
    risePulse(1'b1, 1'b0);
    chk(irqCount - base == 1, "R8 irq on third capture", irqCount - base, 1);
    drain();

    // R4 prescale by 4
    clearAll();
    perIrq = 2'b00;
    setMode(3'b100);
    base = irqCount;
    for (int i = 0; i < 8; i++) risePulse(i % 4 == 3, 1'b0);
    chk(irqCount - base == 2, "R4 two captures in 8 rising edges", irqCount - base, 2);
    drain();

    // R4 prescale by 16
    clearAll();
    setMode(3'b101);
    for (int i = 0; i < 16; i++) risePulse(i == 15, 1'b0);
    drain();

    // R12 mode change restarts prescaler
    clearAll();
    setMode(3'b100);
    for (int i = 0; i < 3; i++) risePulse(1'b0, 1'b0);
    setMode(3'b101);
    setMode(3'b100);
    risePulse(1'b0, 1'b0);
    chk(notEmpty == 1'b0, "R12 no capture right after mode change", notEmpty, 0);
    for (int i = 0; i < 3; i++) risePulse(i == 2, 1'b0);
    drain();

    // R7 overflow and stickiness
    clearAll();
    setMode(3'b011);
    for (int i = 0; i < 5; i++) risePulse(i < 4, 1'b0);
    chk(overflow == 1'b1, "R7 overflow on fifth capture", overflow, 1);
    drain();
    chk(overflow == 1'b1, "R7 overflow sticky after reads", overflow, 1);
    clearAll();
    chk(overflow == 1'b0, "R1 mode 000 clears overflow", overflow, 0);

    // R6 read on empty has no effect
    setMode(3'b011);
    popOne();
    risePulse(1'b1, 1'b0);
    chk(notEmpty == 1'b1, "R6 one entry after empty read", notEmpty, 1);
    drain();

    // R10 external interrupt mode
    clearAll();
    setMode(3'b111);
    base = irqCount;
    drive(1'b1, 1'b0);
    chk(irqCount - base == 1, "R10 irq on rising edge", irqCount - base, 1);
    drive(1'b0, 1'b0);
    chk(irqCount - base == 1, "R10 no irq on falling edge", irqCount - base, 1);
    chk(notEmpty == 1'b0, "R10 nothing stored", notEmpty, 0);

    // R1 reserved code 110 inert
    setMode(3'b110);
    base = irqCount;
    risePulse(1'b0, 1'b0);
    chk(notEmpty == 1'b0 && irqCount == base, "R1 code 110 inert", irqCount - base, 0);

    // R11 halt in idle
    clearAll();
    setMode(3'b011);
    stopInIdle = 1'b1;
    idleIn = 1'b1;
    base = irqCount;
    risePulse(1'b0, 1'b0);
    chk(notEmpty == 1'b0 && irqCount == base, "R11 halted while idle", irqCount - base, 0);
    stopInIdle = 1'b0;
    risePulse(1'b1, 1'b0);
    chk(irqCount - base == 1, "R11 runs in idle when not stopped", irqCount - base, 1);
    idleIn = 1'b0;
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule